// File: doc/BRIEF.md
# Packed SIMD Lane Shifter

This block shifts a 64-bit packed-integer operand lane by lane. A lane-size input selects how the operand is split: four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. A shift-type input selects logical left, logical right or arithmetic right. Every lane moves by the same amount, which comes from a 64-bit unsigned count operand. Carries are cut at each lane edge, so no bit moves from one lane into the next.

Counts at or above the lane width give defined results. Logical shifts clear the lane. Arithmetic shifts fill the lane with its own sign bit. Two kinds of request are refused: an arithmetic right shift on the 64-bit lane size, and any reserved code. For these the block raises an illegal-combination flag and returns zero. By default one output register stage follows the datapath, with a one-cycle valid handshake. A parameter can remove that stage and leave a purely combinational unit.

Top module: `pshift_top`

## Requirements
- R1: The lane-size code divides the operand as follows: 0 gives four 16-bit lanes, 1 gives two 32-bit lanes and 2 gives one 64-bit lane. Lane k occupies bits [k*W +: W], and every lane is shifted by the same count.
- R2: Shift-type code 0 is a logical left shift that fills the vacated low-order bits of each lane with zeros. A count of 0 returns the data unchanged.
- R3: Shift-type code 1 is a logical right shift that fills the vacated high-order bits of each lane with zeros.
- R4: Shift-type code 2 is an arithmetic right shift that copies each lane's own most significant bit into the vacated high-order bits of that lane.
- R5: The count is an unsigned 64-bit value. When it is equal to or greater than the lane width, a logical shift returns an all-zero lane and an arithmetic shift returns a lane filled with that lane's sign bit.
- R6: Shift-type 2 with lane-size code 2 sets out_illegal to 1 and forces out_data to zero.
- R7: No bit shifted out of one lane appears in any neighbouring lane.
- R8: out_valid follows in_valid one clock later, and out_data and out_illegal belong to the request captured on that edge. When in_valid is low, out_valid falls and out_data holds its last value.
- R9: While rst is high, and in the cycle after it, out_valid, out_data and out_illegal are all zero.
- R10: Lane-size code 3 or shift-type code 3 sets out_illegal to 1 and forces out_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 64 | Packed operand |
| in_count | input | 64 | Unsigned shift amount, shared by all lanes |
| in_lane | input | 2 | Lane-size code (0:16, 1:32, 2:64, 3:reserved) |
| in_kind | input | 2 | Shift type (0:logical left, 1:logical right, 2:arithmetic right, 3:reserved) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Shifted operand, or zero when illegal |
| out_illegal | output | 1 | Illegal lane/type combination |

## Verification
The datapath holds no state beyond one register stage, so any internal fault shows at the ports on the very next cycle after the request that triggers it. A wrong lane-width decode or a missing carry cut only shows up with patterns that put set bits next to lane edges. The bench therefore loads alternating edge bits and checks neighbouring lanes, using counts of 1 and lane-1. A saturation fault shows only at counts equal to the lane width or larger. The bench covers it with counts equal to the width, 64, and values whose only set bits sit in the upper count word.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

   typedef enum logic [1:0] {
      SK_LSL  = 2'd0,
      SK_LSR  = 2'd1,
      SK_ASR  = 2'd2,
      SK_RSVD = 2'd3
   } shift_kind_e;

   function automatic int lane_width(input int min_lane, input int size_idx);
      return min_lane << size_idx;
   endfunction

endpackage

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
   import simd_shift_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int CNT_W  = 64
) (
   input  logic [LANE_W-1:0] lane_in,
   input  logic [CNT_W-1:0]  count,
   input  shift_kind_e       kind,
   output logic [LANE_W-1:0] lane_out
);

   localparam int SH_W = $clog2(LANE_W);

   if ((1 << SH_W) != LANE_W) begin : g_chk_pow2
      $error("lane_shift_unit: LANE_W must be a power of two");
   end
   if (CNT_W <= SH_W) begin : g_chk_cnt
      $error("lane_shift_unit: CNT_W must exceed the shift field");
   end

   logic              over;
   logic [SH_W-1:0]   amt;
   logic              sign_bit;

   // any bit at or above the lane-width field means the count saturates
   assign over     = |count[CNT_W-1:SH_W];
   assign amt      = count[SH_W-1:0];
   assign sign_bit = lane_in[LANE_W-1];

   always_comb begin
      unique case (kind)
         SK_LSL:  lane_out = over ? '0 : (lane_in << amt);
         SK_LSR:  lane_out = over ? '0 : (lane_in >> amt);
         SK_ASR:  lane_out = over ? {LANE_W{sign_bit}}
                                  : LANE_W'($signed(lane_in) >>> amt);
         default: lane_out = '0;
      endcase
   end

endmodule

// File: rtl/shift_lane_bank.sv
module shift_lane_bank
   import simd_shift_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16,
   parameter int CNT_W  = 64
) (
   input  logic [DATA_W-1:0] in_data,
   input  logic [CNT_W-1:0]  in_count,
   input  shift_kind_e       in_kind,
   output logic [DATA_W-1:0] bank_out
);

   localparam int N_LANES = DATA_W / LANE_W;

   if (N_LANES * LANE_W != DATA_W) begin : g_chk_div
      $error("shift_lane_bank: DATA_W must be a multiple of LANE_W");
   end

   // each lane is an independent shifter; no signal crosses a lane edge
   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      lane_shift_unit #(
         .LANE_W (LANE_W),
         .CNT_W  (CNT_W)
      ) u_lane (
         .lane_in  (in_data[l*LANE_W +: LANE_W]),
         .count    (in_count),
         .kind     (in_kind),
         .lane_out (bank_out[l*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/shift_select.sv
module shift_select
   import simd_shift_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int NUM_SZ = 3,
   parameter int LSEL_W = 2
) (
   input  logic [NUM_SZ-1:0][DATA_W-1:0] bank_res,
   input  logic [LSEL_W-1:0]             lane_sel,
   input  shift_kind_e                   kind,
   output logic [DATA_W-1:0]             sel_data,
   output logic                          sel_illegal
);

   logic size_bad;
   logic kind_bad;
   logic asr_wide;

   assign size_bad    = int'(lane_sel) >= NUM_SZ;
   assign kind_bad    = (kind == SK_RSVD);
   // the widest lane size has no arithmetic right shift
   assign asr_wide    = (kind == SK_ASR) && (int'(lane_sel) == NUM_SZ - 1);
   assign sel_illegal = size_bad | kind_bad | asr_wide;

   always_comb begin
      sel_data = '0;
      for (int s = 0; s < NUM_SZ; s++) begin
         if (!sel_illegal && int'(lane_sel) == s) sel_data = bank_res[s];
      end
   end

endmodule

// File: rtl/shift_out_stage.sv
module shift_out_stage #(
   parameter int DATA_W     = 64,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_data,
   input  logic              d_illegal,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_data,
   output logic              q_illegal
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q_valid   <= 1'b0;
            q_data    <= '0;
            q_illegal <= 1'b0;
         end else begin
            q_valid <= d_valid;
            if (d_valid) begin
               q_data    <= d_data;
               q_illegal <= d_illegal;
            end
         end
      end
   end else begin : g_comb
      assign q_valid   = d_valid;
      assign q_data    = d_data;
      assign q_illegal = d_illegal;
   end

endmodule

// File: rtl/pshift_top.sv
module pshift_top
   import simd_shift_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int MIN_LANE   = 16,
   parameter int NUM_SZ     = 3,
   parameter int CNT_W      = 64,
   parameter bit REGISTERED = 1'b1,
   localparam int LSEL_W    = (NUM_SZ > 2) ? $clog2(NUM_SZ) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CNT_W-1:0]  in_count,
   input  logic [LSEL_W-1:0] in_lane,
   input  logic [1:0]        in_kind,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_illegal
);

   if ((MIN_LANE << (NUM_SZ - 1)) != DATA_W) begin : g_chk_sizes
      $error("pshift_top: widest lane must equal DATA_W");
   end

   shift_kind_e                   kind;
   logic [NUM_SZ-1:0][DATA_W-1:0] bank_res;
   logic [DATA_W-1:0]             sel_data;
   logic                          sel_illegal;

   assign kind = shift_kind_e'(in_kind);

   for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
      shift_lane_bank #(
         .DATA_W (DATA_W),
         .LANE_W (lane_width(MIN_LANE, s)),
         .CNT_W  (CNT_W)
      ) u_bank (
         .in_data  (in_data),
         .in_count (in_count),
         .in_kind  (kind),
         .bank_out (bank_res[s])
      );
   end

   shift_select #(
      .DATA_W (DATA_W),
      .NUM_SZ (NUM_SZ),
      .LSEL_W (LSEL_W)
   ) u_sel (
      .bank_res    (bank_res),
      .lane_sel    (in_lane),
      .kind        (kind),
      .sel_data    (sel_data),
      .sel_illegal (sel_illegal)
   );

   shift_out_stage #(
      .DATA_W     (DATA_W),
      .REGISTERED (REGISTERED)
   ) u_out (
      .clk       (clk),
      .rst       (rst),
      .d_valid   (in_valid),
      .d_data    (sel_data),
      .d_illegal (sel_illegal),
      .q_valid   (out_valid),
      .q_data    (out_data),
      .q_illegal (out_illegal)
   );

   if (REGISTERED) begin : g_props
      logic in_legal;
      assign in_legal = (int'(in_lane) < NUM_SZ) && (in_kind != 2'd3) &&
                        !((in_kind == 2'd2) && (int'(in_lane) == NUM_SZ - 1));

      p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      p_idle_drop_r8: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
      p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
         out_illegal |-> (out_data == '0));
      p_asr_wide_flag_r6: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_kind == 2'd2 && int'(in_lane) == NUM_SZ - 1)
         |=> out_illegal);
      p_zero_count_r2: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_legal && in_count == '0) |=> (out_data == $past(in_data)));
      p_big_logical_r5: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_legal && in_kind != 2'd2 && in_count >= CNT_W'(DATA_W))
         |=> (out_data == '0));
   end

endmodule

// File: tb/tb_pshift_top.sv
`timescale 1ns/1ps
module tb_pshift_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] in_data;
   logic [63:0] in_count;
   logic [1:0]  in_lane;
   logic [1:0]  in_kind;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_illegal;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pshift_top dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_count(in_count), .in_lane(in_lane), .in_kind(in_kind),
      .out_valid(out_valid), .out_data(out_data), .out_illegal(out_illegal)
   );

   // reference: bit 64 = illegal, bits 63:0 = result
   function automatic logic [64:0] model(input logic [63:0] d, input logic [63:0] c,
                                         input int lane, input int kind);
      int lw;
      logic [63:0] mask, v, r, res;
      logic signed [63:0] sv;
      if (lane > 2 || kind > 2 || (kind == 2 && lane == 2)) return {1'b1, 64'd0};
      lw   = 16 << lane;
      mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
      res  = '0;
      for (int l = 0; l < 64 / lw; l++) begin
         v = (d >> (l * lw)) & mask;
         if (kind == 0)
            r = (c >= 64'(lw)) ? 64'd0 : ((v << c[5:0]) & mask);
         else if (kind == 1)
            r = (c >= 64'(lw)) ? 64'd0 : (v >> c[5:0]);
         else begin
            sv = $signed(v << (64 - lw)) >>> (64 - lw);
            if (c >= 64'(lw)) r = (sv < 0) ? mask : 64'd0;
            else              r = 64'(sv >>> c[5:0]) & mask;
         end
         res = res | (r << (l * lw));
      end
      return {1'b0, res};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_one(input string req, input logic [63:0] d, input logic [63:0] c,
                          input int lane, input int kind);
      logic [64:0] exp;
      exp = model(d, c, lane, kind);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_count = c;
      in_lane = 2'(lane); in_kind = 2'(kind);
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, 64'(out_valid), 64'd1);
      check({req, " data"}, out_data, exp[63:0]);
      check({req, " illegal"}, 64'(out_illegal), 64'(exp[64]));
   endtask

   task automatic t_reset_r9();
      rst = 1'b1; in_valid = 1'b1; in_data = '1; in_count = 64'd1;
      in_lane = 2'd0; in_kind = 2'd0;
      repeat (3) @(negedge clk);
      check("R9 valid", 64'(out_valid), 64'd0);
      check("R9 data", out_data, 64'd0);
      check("R9 illegal", 64'(out_illegal), 64'd0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check("R9 after release", 64'(out_valid), 64'd0);
   endtask

   task automatic t_sweep(input string req, input int kind, input logic [63:0] d);
      for (int lane = 0; lane < 3; lane++) begin
         int lw = 16 << lane;
         if (!(kind == 2 && lane == 2)) begin
            run_one(req, d, 64'd0, lane, kind);
            run_one(req, d, 64'd1, lane, kind);
            run_one(req, d, 64'(lw - 1), lane, kind);
            run_one(req, d, 64'(lw / 2 + 3), lane, kind);
         end
      end
   endtask

   task automatic t_saturate_r5();
      for (int lane = 0; lane < 3; lane++) begin
         int lw = 16 << lane;
         for (int kind = 0; kind < 3; kind++) begin
            if (!(kind == 2 && lane == 2)) begin
               run_one("R5 count=lane", 64'h8123_7FFF_F000_0001, 64'(lw), lane, kind);
               run_one("R5 count=64", 64'hF00D_8000_7FFF_0FFF, 64'd64, lane, kind);
               run_one("R5 high word", 64'h8000_8000_0001_8001, 64'h1_0000_0000, lane, kind);
               run_one("R5 max", 64'hFFFF_0000_8000_1234, '1, lane, kind);
            end
         end
      end
      // explicit values: lanes 0x8000/0x7FFF under arithmetic saturation
      run_one("R5 sign fill", 64'h7FFF_8000_7FFF_8000, 64'd16, 0, 2);
      check("R5 sign fill const", out_data, 64'h0000_FFFF_0000_FFFF);
   endtask

   task automatic t_isolation_r7();
      run_one("R7 lsl edge16", 64'h8001_8001_8001_8001, 64'd1, 0, 0);
      check("R7 lsl edge16 const", out_data, 64'h0002_0002_0002_0002);
      run_one("R7 lsr edge16", 64'h8001_8001_8001_8001, 64'd1, 0, 1);
      check("R7 lsr edge16 const", out_data, 64'h4000_4000_4000_4000);
      run_one("R7 lsl edge32", 64'h8000_0001_8000_0001, 64'd31, 1, 0);
      check("R7 lsl edge32 const", out_data, 64'h8000_0000_8000_0000);
      run_one("R7 asr edge32", 64'h0000_0001_8000_0000, 64'd4, 1, 2);
      check("R7 asr edge32 const", out_data, 64'h0000_0000_F800_0000);
   endtask

   task automatic t_lanes_r1();
      run_one("R1 16-bit", 64'h1234_5678_9ABC_DEF0, 64'd4, 0, 1);
      check("R1 16-bit const", out_data, 64'h0123_0567_09AB_0DEF);
      run_one("R1 32-bit", 64'h1234_5678_9ABC_DEF0, 64'd4, 1, 1);
      check("R1 32-bit const", out_data, 64'h0123_4567_09AB_CDEF);
      run_one("R1 64-bit", 64'h1234_5678_9ABC_DEF0, 64'd4, 2, 1);
      check("R1 64-bit const", out_data, 64'h0123_4567_89AB_CDEF);
   endtask

   task automatic t_asr_wide_r6();
      run_one("R6 asr 64", 64'h8000_0000_0000_0001, 64'd1, 2, 2);
      check("R6 flag", 64'(out_illegal), 64'd1);
      run_one("R6 legal after", 64'h8000_0000_0000_0001, 64'd1, 2, 1);
      check("R6 flag clear", 64'(out_illegal), 64'd0);
   endtask

   task automatic t_reserved_r10();
      run_one("R10 lane code 3", 64'hDEAD_BEEF_0123_4567, 64'd2, 3, 0);
      run_one("R10 kind code 3", 64'hDEAD_BEEF_0123_4567, 64'd2, 1, 3);
   endtask

   task automatic t_handshake_r8();
      logic [64:0] exp;
      exp = model(64'hAAAA_5555_0F0F_F0F0, 64'd3, 0, 0);
      run_one("R8 load", 64'hAAAA_5555_0F0F_F0F0, 64'd3, 0, 0);
      // idle cycle with changed inputs: valid drops, data holds
      in_data = '1; in_count = 64'd9;
      @(negedge clk);
      check("R8 valid low", 64'(out_valid), 64'd0);
      check("R8 data hold", out_data, exp[63:0]);
   endtask

   initial begin
      t_reset_r9();
      t_lanes_r1();
      t_sweep("R2 lsl", 0, 64'hC3A5_8001_7FFE_1234);
      t_sweep("R3 lsr", 1, 64'hC3A5_8001_7FFE_1234);
      t_sweep("R4 asr", 2, 64'hC3A5_8001_7FFE_1234);
      t_sweep("R4 asr pos", 2, 64'h7F00_0F0F_3C3C_0001);
      t_saturate_r5();
      t_isolation_r7();
      t_asr_wide_r6();
      t_reserved_r10();
      t_handshake_r8();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule